// File: doc/BRIEF.md
# Multi-mode logarithmic word shifter

This block moves a data word right or left by any distance from zero to one less than the word width, inside a single combinational path. The datapath is a cascade of two-input multiplexer stages. Stage k either passes the word through or moves it right by 2^k positions, and bit k of the distance selects which. At the top of every stage, each bit line that the move empties goes through a three-way fill selector. The selector picks the bit that wrapped around for a rotation, the word's top bit for an arithmetic move, or a constant zero.

There is only a right-moving datapath; left operations are built on it. A left rotation by L becomes a right rotation by the two's complement of L, formed by inverting L and incrementing. So a rotation by zero still gives the unchanged word, because the negated distance wraps to zero. A left shift reverses the word's bit order, shifts right by L with zero fill, and reverses the result back. The block has no clock and no state. A caller places it between its own registers.

Top module: `lsh_shifter`

## Requirements
- R1: When `shamt` is 0, `dout` equals `din` for every value of `dir_left` and `fill_mode`.
- R2: With `dir_left`=0 and `fill_mode`=2'b00 (logical), `dout` is `din` moved right by `shamt` positions, and the `shamt` topmost bits are 0.
- R3: With `dir_left`=0 and `fill_mode`=2'b01 (arithmetic), `dout` is `din` moved right by `shamt` positions, and the `shamt` topmost bits copy `din[WIDTH-1]`.
- R4: With `dir_left`=0 and `fill_mode`=2'b10 (rotate), `dout[i]` = `din[(i+shamt) mod WIDTH]`.
- R5: With `dir_left`=1 and `fill_mode`=2'b10, `dout[i]` = `din[(i-shamt) mod WIDTH]`. This is a left rotation made as a right rotation by the negated distance.
- R6: With `dir_left`=1 and `fill_mode` 2'b00, 2'b01 or 2'b11, `dout` is `din` moved left by `shamt` positions, and the `shamt` lowest bits are 0. The top bit gets no special treatment on a left move.
- R7: `fill_mode`=2'b11 gives the same result as 2'b00 in both directions.
- R8: The largest distance, WIDTH-1, gives the results that R2 to R6 define. A right logical shift by that distance leaves only `din[WIDTH-1]` at bit 0, and a left shift leaves only `din[0]` at the top bit.
- R9: `dout` is a pure function of the present inputs. It reflects a new input value within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | WIDTH | Word to be moved |
| shamt | input | $clog2(WIDTH) | Move distance in bit positions |
| dir_left | input | 1 | 1 selects a left move, 0 a right move |
| fill_mode | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 treated as logical |
| dout | output | WIDTH | Moved or rotated word |

## Verification
The bench instantiates the shifter twice, once at the default WIDTH of 16 and once at WIDTH 8. At width 8 it applies every combination of data byte, distance, direction and fill mode. That covers each stage, each fill bit line and the wrap of the negated distance in full. At width 16 it first sweeps four edge patterns over all distances, directions and modes. It then runs a long pseudo-random sequence, which exercises the four-stage cascade and the sign and wrap paths of the wider word.

// File: rtl/lsh_pkg.sv
package lsh_pkg;

  // Fill behaviour seen by each stage on the bit lines that a right move empties
  typedef enum logic [1:0] {
    FILL_ZERO = 2'b00,
    FILL_SIGN = 2'b01,
    FILL_WRAP = 2'b10
  } fill_e;

  // Encodings of the fill_mode input of the top module
  localparam logic [1:0] MODE_LOGIC  = 2'b00;
  localparam logic [1:0] MODE_ARITH  = 2'b01;
  localparam logic [1:0] MODE_ROTATE = 2'b10;

endpackage

// File: rtl/lsh_bitrev.sv
module lsh_bitrev #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign y[i] = a[W-1-i];
  end
endmodule

// File: rtl/lsh_amt_negate.sv
module lsh_amt_negate #(
  parameter int AW = 4
) (
  input  logic [AW-1:0] amt,
  output logic [AW-1:0] neg
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] inv;

  // two's complement: invert every bit, then increment (wraps 0 -> 0)
  assign inv = ~amt;
  assign neg = inv + ONE;
endmodule

// File: rtl/lsh_stage.sv
module lsh_stage
  import lsh_pkg::*;
#(
  parameter int W    = 16,
  parameter int DIST = 1
) (
  input  logic [W-1:0] d,
  input  logic         en,
  input  fill_e        fill,
  output logic [W-1:0] q
);
  logic [W-1:0] moved;

  for (genvar i = 0; i < W; i++) begin : g_line
    if (i + DIST < W) begin : g_body
      assign moved[i] = d[i+DIST];
    end else begin : g_fill
      // three-way selector on each bit line the move empties
      always_comb begin
        unique case (fill)
          FILL_WRAP: moved[i] = d[i+DIST-W];
          FILL_SIGN: moved[i] = d[W-1];
          default:   moved[i] = 1'b0;
        endcase
      end
    end
  end

  assign q = en ? moved : d;
endmodule

// File: rtl/lsh_shifter.sv
module lsh_shifter
  import lsh_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int AW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AW-1:0]    shamt,
  input  logic             dir_left,
  input  logic [1:0]       fill_mode,
  output logic [WIDTH-1:0] dout
);
  localparam int NSTAGE = AW;

  logic             is_rot;
  logic             is_arith_r;
  logic             use_rev;
  logic             use_neg;
  fill_e            eff_fill;
  logic [AW-1:0]    amt_neg;
  logic [AW-1:0]    amt_eff;
  logic [WIDTH-1:0] din_rev;
  logic [WIDTH-1:0] core_in;
  logic [WIDTH-1:0] core_out;
  logic [WIDTH-1:0] out_rev;
  logic [WIDTH-1:0] stage_v [NSTAGE+1];

  // mode decode; left non-rotating moves always fill with zero
  always_comb begin
    is_rot     = (fill_mode == MODE_ROTATE);
    is_arith_r = (fill_mode == MODE_ARITH) && !dir_left;
    use_neg    = dir_left && is_rot;
    use_rev    = dir_left && !is_rot;
    if (is_rot)          eff_fill = FILL_WRAP;
    else if (is_arith_r) eff_fill = FILL_SIGN;
    else                 eff_fill = FILL_ZERO;
  end

  lsh_amt_negate #(.AW(AW)) u_neg (
    .amt (shamt),
    .neg (amt_neg)
  );

  assign amt_eff = use_neg ? amt_neg : shamt;

  lsh_bitrev #(.W(WIDTH)) u_rev_in (
    .a (din),
    .y (din_rev)
  );

  assign core_in    = use_rev ? din_rev : din;
  assign stage_v[0] = core_in;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    lsh_stage #(.W(WIDTH), .DIST(1 << k)) u_stage (
      .d    (stage_v[k]),
      .en   (amt_eff[k]),
      .fill (eff_fill),
      .q    (stage_v[k+1])
    );
  end

  assign core_out = stage_v[NSTAGE];

  lsh_bitrev #(.W(WIDTH)) u_rev_out (
    .a (core_out),
    .y (out_rev)
  );

  assign dout = use_rev ? out_rev : core_out;

endmodule

// File: rtl/lsh_shifter_chk.sv
module lsh_shifter_chk #(
  parameter int WIDTH = 16,
  localparam int AW   = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] din,
  input logic [AW-1:0]    shamt,
  input logic             dir_left,
  input logic [1:0]       fill_mode,
  input logic [WIDTH-1:0] dout
);
  always_comb begin
    // R1
    zero_amt_identity_chk: assert (shamt != '0 || dout == din);
    // R4
    rot_keeps_ones_chk: assert (fill_mode != 2'b10 || $countones(dout) == $countones(din));
    // R3
    arith_sign_kept_chk: assert (!(fill_mode == 2'b01 && !dir_left) || dout[WIDTH-1] == din[WIDTH-1]);
    // R2
    logic_top_clear_chk: assert (!(fill_mode == 2'b00 && !dir_left && shamt != '0) || !dout[WIDTH-1]);
    // R6
    left_low_clear_chk: assert (!(dir_left && fill_mode != 2'b10 && shamt != '0) || !dout[0]);
    // R5
    lrot_lsb_wrap_chk: assert (!(dir_left && fill_mode == 2'b10) || dout[shamt] == din[0]);
  end
endmodule

bind lsh_shifter lsh_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .din       (din),
  .shamt     (shamt),
  .dir_left  (dir_left),
  .fill_mode (fill_mode),
  .dout      (dout)
);

// File: tb/lsh_shifter_tb.sv
module lsh_shifter_tb;
  logic clk;
  logic rst_n;
  int   errors = 0;
  int   checks = 0;
  bit   done = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] d16, y16;
  logic [3:0]  a16;
  logic        l16;
  logic [1:0]  m16;
  logic [7:0]  d8, y8;
  logic [2:0]  a8;
  logic        l8;
  logic [1:0]  m8;

  lsh_shifter u_dut (
    .din (d16), .shamt (a16), .dir_left (l16), .fill_mode (m16), .dout (y16)
  );

  lsh_shifter #(.WIDTH(8)) u_dut8 (
    .din (d8), .shamt (a8), .dir_left (l8), .fill_mode (m8), .dout (y8)
  );

  // behavioural model written from the requirements
  function automatic logic [15:0] model(int w, logic [15:0] d, int amt, bit left, logic [1:0] m);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < w; i++) begin
      if (m == 2'b10 && !left)      r[i] = d[(i + amt) % w];
      else if (m == 2'b10)          r[i] = d[(i - amt + w) % w];
      else if (left)                r[i] = (i >= amt) ? d[i-amt] : 1'b0;
      else if (i + amt < w)         r[i] = d[i+amt];
      else                          r[i] = (m == 2'b01) ? d[w-1] : 1'b0;
    end
    return r;
  endfunction

  function automatic string tag(int w, int amt, bit left, logic [1:0] m);
    if (amt == 0)            return "R1";
    if (amt == w - 1)        return "R8";
    if (m == 2'b10)          return left ? "R5" : "R4";
    if (left)                return "R6";
    if (m == 2'b01)          return "R3";
    if (m == 2'b11)          return "R7";
    return "R2";
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    logic [31:0] lfsr;
    logic [15:0] pats [4];
    pats[0] = 16'h8000; pats[1] = 16'h0001; pats[2] = 16'hA5C3; pats[3] = 16'h7FFF;
    rst_n = 1'b0;
    d16 = '0; a16 = '0; l16 = 1'b0; m16 = 2'b00;
    d8 = '0; a8 = '0; l8 = 1'b0; m8 = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", y16, 16'h0000);
    chk("R1", {8'h00, y8}, 16'h0000);
    rst_n = 1'b1;

    // R9: output follows inputs with no clock edge in between
    @(negedge clk);
    d16 = 16'h9234; a16 = 4'd3; l16 = 1'b0; m16 = 2'b01;
    #1 chk("R9", y16, 16'hF246);
    d16 = 16'h0F0F; a16 = 4'd15; l16 = 1'b0; m16 = 2'b00;
    #1 chk("R8", y16, 16'h0000);
    d16 = 16'h8001; a16 = 4'd15; l16 = 1'b1; m16 = 2'b00;
    #1 chk("R8", y16, 16'h8000);
    d16 = 16'h1234; a16 = 4'd4; l16 = 1'b1; m16 = 2'b10;
    #1 chk("R5", y16, 16'h2341);
    d16 = 16'h1234; a16 = 4'd4; l16 = 1'b0; m16 = 2'b11;
    #1 chk("R7", y16, 16'h0123);

    // directed sweep at width 16
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 4; m++)
        for (int lf = 0; lf < 2; lf++)
          for (int a = 0; a < 16; a++) begin
            @(posedge clk);
            d16 = pats[p]; a16 = a[3:0]; l16 = lf[0]; m16 = m[1:0];
            @(negedge clk);
            chk(tag(16, a, lf[0], m[1:0]), y16, model(16, pats[p], a, lf[0], m[1:0]));
          end

    // exhaustive at width 8, pseudo-random at width 16
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 16384; n++) begin
      @(posedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      d8 = n[7:0]; a8 = n[10:8]; l8 = n[11]; m8 = n[13:12];
      d16 = lfsr[15:0] ^ lfsr[31:16]; a16 = lfsr[19:16]; l16 = lfsr[20]; m16 = lfsr[22:21];
      @(negedge clk);
      chk(tag(8, int'(a8), l8, m8), {8'h00, y8}, model(8, {8'h00, d8}, int'(a8), l8, m8));
      chk(tag(16, int'(a16), l16, m16), y16, model(16, d16, int'(a16), l16, m16));
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule